// File: doc/BRIEF.md
# Dual-Band Buffer Occupancy Monitor

This block watches the fill level of one or two receive sample buffers, one for each frequency band. Each buffer reports its live level, counted in elements of two samples each, and a one-cycle pulse when it overruns. For each band the monitor keeps a high-water mark and a sticky overrun flag. A host reaches these values through a small word-addressed register port that also holds a scratch register, which the host uses to test the connection.

A single write to address 0 clears the flags and restarts the high-water marks. The host can then poll at any interval it likes and see the worst case since its last clear. A parameter sets how many bands are active. When only one band is active, every band-1 location reads as zero.

Top module: `occ_mon_top`

## Requirements
- R1: A read of address 0 returns the band-0 live level and a read of address 1 returns the band-1 live level, both in elements of two samples each. The level is zero-extended to the data width and sampled in the cycle of the read strobe.
- R2: A read of address 2 returns the band-0 high-water mark and a read of address 3 returns the band-1 mark. A mark takes the live level on every clock in which that level is above the stored mark, and holds its value otherwise.
- R3: A read of address 4 returns the overrun flags, with band 0 in bit 0 and band 1 in bit 1 and all other bits zero. An overrun pulse sets its band's flag, and the flag stays set until the clearing write, even after the buffer drains.
- R4: A write to address 0, with any data, clears both flags and loads each high-water mark with the live level present in that cycle. An overrun pulse in that same cycle leaves its flag set.
- R5: Address 7 is a scratch register of the full data width. Any value written there, for example 0x55AA, reads back unchanged.
- R6: Read data appears on the cycle after the read strobe, and reg_rvalid is high in exactly that cycle. reg_rvalid is low on every cycle that does not follow a strobe. A read and a write in the same cycle return the value held before the write.
- R7: Addresses 5 and 6 read as zero. Writes to addresses 1 to 6 change no register.
- R8: With NUM_BANDS set to 1, addresses 1 and 3 read zero and flag bit 1 reads zero, whatever the band-1 inputs do.
- R9: A synchronous active-high reset clears the flags, the high-water marks, the scratch register and reg_rvalid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_b0 | input | OCC_W | Band-0 live level in elements |
| lvl_b1 | input | OCC_W | Band-1 live level in elements |
| ovf_b0 | input | 1 | Band-0 overrun pulse |
| ovf_b1 | input | 1 | Band-1 overrun pulse |
| reg_addr | input | ADDR_W | Word address |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, one cycle after the strobe |
| reg_rvalid | output | 1 | High in the cycle that read data is valid |

## Verification
The assertions assume that the level and overrun inputs, and all register strobes, are synchronous to clk and free of unknown values. They also assume that the address stays valid in any cycle with a strobe, and that a level never exceeds OCC_W bits. The bench changes every input only on the falling edge and draws levels within 16 bits. It mixes reads, writes and clears freely, and includes clears that land in the same cycle as an overrun pulse or a read.

// File: rtl/occ_mon_pkg.sv
package occ_mon_pkg;
  // Word addresses decoded by the host driver; the offsets are part of the contract.
  localparam int unsigned A_LIVE0   = 0;  // also the clear address on write
  localparam int unsigned A_LIVE1   = 1;
  localparam int unsigned A_PEAK0   = 2;
  localparam int unsigned A_PEAK1   = 3;
  localparam int unsigned A_FLAGS   = 4;
  localparam int unsigned A_SCRATCH = 7;
  localparam int unsigned MAX_BANDS = 2;
endpackage

// File: rtl/occ_band_track.sv
module occ_band_track #(
  parameter int OCC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [OCC_W-1:0] lvl,
  input  logic             ovf,
  output logic [OCC_W-1:0] peak,
  output logic             flag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      peak <= '0;
      flag <= 1'b0;
    end else if (clr) begin
      peak <= lvl;
      flag <= ovf;
    end else begin
      if (lvl > peak) peak <= lvl;
      if (ovf) flag <= 1'b1;
    end
  end
endmodule

// File: rtl/occ_regfile.sv
module occ_regfile
  import occ_mon_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int OCC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OCC_W-1:0]  lvl0,
  input  logic [OCC_W-1:0]  lvl1,
  input  logic [OCC_W-1:0]  peak0,
  input  logic [OCC_W-1:0]  peak1,
  input  logic [1:0]        flags,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              clr
);
  localparam int PAD = DATA_W - OCC_W;

  logic [DATA_W-1:0] scratch_q;
  logic [DATA_W-1:0] sel_data;

  assign clr = wr && (addr == ADDR_W'(A_LIVE0));

  always_comb begin
    sel_data = '0;
    case (addr)
      ADDR_W'(A_LIVE0):   sel_data = {{PAD{1'b0}}, lvl0};
      ADDR_W'(A_LIVE1):   sel_data = {{PAD{1'b0}}, lvl1};
      ADDR_W'(A_PEAK0):   sel_data = {{PAD{1'b0}}, peak0};
      ADDR_W'(A_PEAK1):   sel_data = {{PAD{1'b0}}, peak1};
      ADDR_W'(A_FLAGS):   sel_data = {{(DATA_W-2){1'b0}}, flags};
      ADDR_W'(A_SCRATCH): sel_data = scratch_q;
      default:            sel_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      rvalid    <= 1'b0;
      scratch_q <= '0;
    end else begin
      rvalid <= rd;
      if (rd) rdata <= sel_data;
      if (wr && (addr == ADDR_W'(A_SCRATCH))) scratch_q <= wdata;
    end
  end
endmodule

// File: rtl/occ_mon_top.sv
module occ_mon_top
  import occ_mon_pkg::*;
#(
  parameter int NUM_BANDS = 2,
  parameter int OCC_W     = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OCC_W-1:0]  lvl_b0,
  input  logic [OCC_W-1:0]  lvl_b1,
  input  logic              ovf_b0,
  input  logic              ovf_b1,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid
);
  logic [OCC_W-1:0] lvl_in  [MAX_BANDS];
  logic [OCC_W-1:0] lvl_v   [MAX_BANDS];
  logic [OCC_W-1:0] peak_v  [MAX_BANDS];
  logic [MAX_BANDS-1:0] ovf_in;
  logic [MAX_BANDS-1:0] flag_v;
  logic clr_all;

  assign lvl_in[0] = lvl_b0;
  assign lvl_in[1] = lvl_b1;
  assign ovf_in    = {ovf_b1, ovf_b0};

  for (genvar b = 0; b < MAX_BANDS; b++) begin : g_band
    if (b < NUM_BANDS) begin : g_on
      assign lvl_v[b] = lvl_in[b];
      occ_band_track #(.OCC_W(OCC_W)) u_trk (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_all),
        .lvl  (lvl_in[b]),
        .ovf  (ovf_in[b]),
        .peak (peak_v[b]),
        .flag (flag_v[b])
      );
    end else begin : g_off
      assign lvl_v[b]  = '0;
      assign peak_v[b] = '0;
      assign flag_v[b] = 1'b0;
    end
  end

  occ_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OCC_W(OCC_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .lvl0   (lvl_v[0]),
    .lvl1   (lvl_v[1]),
    .peak0  (peak_v[0]),
    .peak1  (peak_v[1]),
    .flags  (flag_v),
    .addr   (reg_addr),
    .rd     (reg_rd),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .rvalid (reg_rvalid),
    .clr    (clr_all)
  );
endmodule

// File: rtl/occ_mon_chk.sv
module occ_mon_chk #(
  parameter int OCC_W  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [OCC_W-1:0]  lvl_b0,
  input logic              ovf_b0,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              reg_rvalid,
  input logic [OCC_W-1:0]  peak0,
  input logic [1:0]        flags
);
  logic clr_w;
  assign clr_w = reg_wr && (reg_addr == '0);

  assert_peak_covers_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (peak0 >= $past(lvl_b0)));

  assert_peak_holds_R2: assert property (@(posedge clk) disable iff (rst)
    !clr_w |=> (peak0 >= $past(peak0)));

  assert_flag_sets_R3: assert property (@(posedge clk) disable iff (rst)
    ovf_b0 |=> flags[0]);

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    (flags[0] && !clr_w) |=> flags[0]);

  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_w && !ovf_b0) |=> (!flags[0] && (peak0 == $past(lvl_b0))));

  assert_scratch_R5: assert property (@(posedge clk) disable iff (rst)
    ((reg_wr && reg_addr == ADDR_W'(7)) ##1 (reg_rd && !reg_wr && reg_addr == ADDR_W'(7)))
    |=> (reg_rdata == $past(reg_wdata, 2)));

  assert_rvalid_R6: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);

  assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> !reg_rvalid);
endmodule

bind occ_mon_top occ_mon_chk #(.OCC_W(OCC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .lvl_b0     (lvl_b0),
  .ovf_b0     (ovf_b0),
  .reg_addr   (reg_addr),
  .reg_rd     (reg_rd),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .reg_rvalid (reg_rvalid),
  .peak0      (peak_v[0]),
  .flags      (flag_v)
);

// File: tb/occ_mon_top_tb.sv
module occ_mon_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] lvl_b0 = '0, lvl_b1 = '0;
  logic        ovf_b0 = 1'b0, ovf_b1 = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] rdata2, rdata1;
  logic        rvalid2, rvalid1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state: index [variant][band], variant 0 = two bands, 1 = one band
  int m_peak [2][2];
  int m_flag [2][2];
  longint m_scr [2];

  always #10 clk = ~clk;

  occ_mon_top #(.NUM_BANDS(2)) u_dut (
    .clk(clk), .rst(rst), .lvl_b0(lvl_b0), .lvl_b1(lvl_b1),
    .ovf_b0(ovf_b0), .ovf_b1(ovf_b1), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata2), .reg_rvalid(rvalid2));

  occ_mon_top #(.NUM_BANDS(1)) u_dut1 (
    .clk(clk), .rst(rst), .lvl_b0(lvl_b0), .lvl_b1(lvl_b1),
    .ovf_b0(ovf_b0), .ovf_b1(ovf_b1), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata1), .reg_rvalid(rvalid1));

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint model_read(int v, int a, int l0, int l1);
    int lv1 = (v == 0) ? l1 : 0;
    case (a)
      0: return l0;
      1: return lv1;
      2: return m_peak[v][0];
      3: return m_peak[v][1];
      4: return m_flag[v][0] + 2 * m_flag[v][1];
      7: return m_scr[v];
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int v, int a);
    if (v == 1 && (a == 1 || a == 3 || a == 4)) return "R8";
    case (a)
      0, 1: return "R1";
      2, 3: return "R2";
      4: return "R3";
      7: return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic model_reset();
    for (int v = 0; v < 2; v++) begin
      m_scr[v] = 0;
      for (int b = 0; b < 2; b++) begin
        m_peak[v][b] = 0;
        m_flag[v][b] = 0;
      end
    end
  endtask

  // one clock: drive at negedge, predict, compare at the next negedge
  task automatic cyc(input int l0, input int l1, input bit o0, input bit o1,
                     input bit rd, input bit wr, input int a, input longint wd,
                     input string tag);
    longint exp_rd [2];
    int lv [2];
    bit ov [2];
    lvl_b0 = 16'(l0); lvl_b1 = 16'(l1);
    ovf_b0 = o0; ovf_b1 = o1;
    reg_rd = rd; reg_wr = wr; reg_addr = 3'(a); reg_wdata = 32'(wd);
    for (int v = 0; v < 2; v++) begin
      exp_rd[v] = model_read(v, a, l0, l1);
      lv[0] = l0; lv[1] = (v == 0) ? l1 : 0;
      ov[0] = o0; ov[1] = (v == 0) ? o1 : 1'b0;
      for (int b = 0; b < 2; b++) begin
        if (wr && a == 0) begin
          m_peak[v][b] = lv[b];
          m_flag[v][b] = ov[b] ? 1 : 0;
        end else begin
          if (lv[b] > m_peak[v][b]) m_peak[v][b] = lv[b];
          if (ov[b]) m_flag[v][b] = 1;
        end
      end
      if (wr && a == 7) m_scr[v] = wd;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R6", longint'(rvalid2), longint'(rd));
    chk("R6", longint'(rvalid1), longint'(rd));
    if (rd) begin
      chk((tag != "") ? tag : tag_of(0, a), longint'(rdata2), exp_rd[0]);
      chk((tag != "") ? tag : tag_of(1, a), longint'(rdata1), exp_rd[1]);
    end
  endtask

  task automatic rdc(input int l0, input int l1, input int a, input string tag);
    cyc(l0, l1, 1'b0, 1'b0, 1'b1, 1'b0, a, 0, tag);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    chk("R9", longint'(rvalid2), 0);
    rdc(0, 0, 2, "R9");
    rdc(0, 0, 3, "R9");
    rdc(0, 0, 4, "R9");
    rdc(0, 0, 7, "R9");
    // R1/R2: live levels and rising marks
    rdc(10, 3, 0, "");
    rdc(20, 40, 1, "");
    rdc(5, 7, 2, "");
    rdc(5, 7, 3, "");
    rdc(65535, 1, 0, "R1");
    rdc(2, 1, 2, "R2");
    // R3: sticky overrun flags
    cyc(2, 1, 1'b1, 1'b0, 1'b0, 1'b0, 0, 0, "");
    rdc(0, 0, 4, "R3");
    cyc(0, 0, 1'b0, 1'b1, 1'b0, 1'b0, 0, 0, "");
    rdc(0, 0, 4, "R3");
    rdc(0, 0, 4, "R3");
    // R4: clear restarts marks from live level
    cyc(12, 9, 1'b0, 1'b0, 1'b0, 1'b1, 0, 32'hDEAD, "");
    rdc(3, 4, 2, "R4");
    rdc(3, 4, 3, "R4");
    rdc(3, 4, 4, "R4");
    // R4: overrun in the clearing cycle wins; clear combined with a read
    cyc(30, 6, 1'b1, 1'b0, 1'b1, 1'b1, 0, 0, "R1");
    rdc(1, 1, 4, "R4");
    rdc(1, 1, 2, "R4");
    // R5: scratch
    cyc(1, 1, 1'b0, 1'b0, 1'b0, 1'b1, 7, 32'h55AA, "");
    rdc(1, 1, 7, "R5");
    cyc(1, 1, 1'b0, 1'b0, 1'b1, 1'b1, 7, 32'hFFFF_FFFF, "R6");
    rdc(1, 1, 7, "R5");
    // R7: writes to 1..6 change nothing, 5 and 6 read zero
    for (int a = 1; a < 7; a++)
      cyc(1, 1, 1'b0, 1'b0, 1'b0, 1'b1, a, 32'hA5A5_5A5A, "");
    for (int a = 0; a < 8; a++) rdc(1, 1, a, "");
    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int r = int'($urandom % 16);
      cyc(int'($urandom % 65536), int'($urandom % 65536),
          ($urandom % 9) == 0, ($urandom % 11) == 0,
          ($urandom % 2) == 0, r == 0 || r == 1,
          (r == 1) ? 7 : int'($urandom % 8), longint'($urandom), "");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule